// File: doc/BRIEF.md
# I2C Master with FIFO Pause

This block is an I2C bus master. It takes outgoing bytes from a transmit FIFO and puts incoming bytes into a receive FIFO. One command pulse starts a transfer. The command carries a 7-bit target address, a count of bytes to write and a count of bytes to read. The block generates START, the address byte, the data bytes with their acknowledge bits, an optional repeated START into a read phase, and STOP.

The FIFOs can be shallow because the block does not end a transfer when a FIFO runs dry or fills up. When the next byte to write is not in the transmit FIFO yet, or the receive FIFO has no room for the next byte to read, the controller parks the bus. It holds SCL low after the acknowledge bit and keeps ownership of the bus. It continues on its own as soon as software pushes or pops a byte. A stop request issued while parked ends the transfer cleanly instead. Transfers such as long serial EEPROM page accesses can therefore be far longer than either FIFO.

The SCL rate is set by a divider. Each quarter of a bit lasts `div+1` system clocks. SDA moves only while SCL is low, except for the START and STOP edges.

Top module: `i2c_fifo_master`

## Requirements
- R1: After reset, SCL and SDA are both released (`scl_oe`=0, `sda_oe`=0), `busy`, `waiting` and `nack_err` are 0, and both FIFO levels are 0.
- R2: A write transfer sends START, then the address byte {addr[6:0], 0} MSB first, then `wr_len` bytes taken from the transmit FIFO in push order, MSB first, then STOP.
- R3: A read transfer sends the address byte {addr[6:0], 1} and stores `rd_len` received bytes in the receive FIFO in bus order. The master drives ACK (SDA low) after every received byte except the last, which gets NACK (SDA released), followed by STOP.
- R4: When both `wr_len` and `rd_len` are non-zero, the write phase is followed by a repeated START and a read-addressed phase, with exactly one STOP at the end.
- R5: If the transmit FIFO is empty when another byte must be written, `waiting` rises, SCL is held low and no STOP is issued. The transfer resumes once a byte is pushed.
- R6: If the receive FIFO is full when another byte must be read, `waiting` rises and SCL is held low. The transfer resumes once a byte is popped.
- R7: A `stop_req` pulse while `waiting` is 1 ends the transfer with STOP. No further data bytes are transferred and `nack_err` stays 0.
- R8: A NACK after the address byte or after a written byte ends the transfer with STOP and sets `nack_err`. Transmit bytes not yet sent stay in the FIFO. `nack_err` clears when the next transfer starts.
- R9: The time between successive SCL rising edges inside a byte is 4*(`div`+1) clock cycles.
- R10: SDA changes only while SCL is low, except for the falling edge of START and the rising edge of STOP. The bus therefore sees exactly one START per address phase and one STOP per transfer.
- R11: `tx_level` and `rx_level` give the FIFO occupancy, which never exceeds DEPTH. A push into a full transmit FIFO is dropped, and a pop from an empty receive FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | Quarter-bit length minus one, in clocks |
| tx_push | input | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | input | 8 | Byte to transmit |
| tx_level | output | $clog2(DEPTH)+1 | Transmit FIFO occupancy |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_byte | output | 8 | Head of the receive FIFO |
| rx_level | output | $clog2(DEPTH)+1 | Receive FIFO occupancy |
| go | input | 1 | Start a transfer (accepted when idle) |
| dev_addr | input | 7 | Target address |
| wr_len | input | LEN_W | Bytes to write |
| rd_len | input | LEN_W | Bytes to read |
| stop_req | input | 1 | End a paused transfer with STOP |
| busy | output | 1 | Transfer in progress |
| waiting | output | 1 | Paused on a FIFO condition, SCL held low |
| nack_err | output | 1 | Last transfer was refused by the target |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA line |

## Verification
The hardest condition to reach is the pause partway through a read. The receive FIFO must fill at a byte boundary while a target model is already presenting the first bit of the next byte. The bench uses a FIFO depth of four and asks for seven bytes, so the pause falls after the fourth byte. It then pops the bytes one at a time, and the acknowledge pattern recorded by the bus-level target shows whether the resume clocked the remaining bytes correctly. The write-side pause and the stop-from-pause case are reached the same way: the bench pushes fewer bytes than `wr_len` asks for.

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_push,
  input  logic [7:0]       tx_byte,
  output logic [$clog2(DEPTH):0] tx_level,
  input  logic             rx_pop,
  output logic [7:0]       rx_byte,
  output logic [$clog2(DEPTH):0] rx_level,
  input  logic             go,
  input  logic [6:0]       dev_addr,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [LEN_W-1:0] rd_len,
  input  logic             stop_req,
  output logic             busy,
  output logic             waiting,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_ACK, S_WAIT, S_STOP} st_t;

  st_t st;
  logic [1:0] q;
  logic [2:0] bitn;
  logic [DIV_W-1:0] cnt;
  logic [7:0] sh;
  logic [6:0] addr;
  logic [LEN_W-1:0] wr_left, rd_left;
  logic is_addr, reading, restart, ack_in, stop_pend;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;

  assign tx_level = tx_wp - tx_rp;
  assign rx_level = rx_wp - rx_rp;
  assign rx_byte  = rx_mem[rx_rp[AW-1:0]];
  assign busy     = st != S_IDLE;
  assign waiting  = st == S_WAIT;

  wire tick      = busy && cnt == '0;
  wire write_ph  = is_addr || !reading;
  wire tx_empty  = tx_level == '0;
  wire rx_full   = rx_level == FULL;
  wire need_wait = reading ? (rd_left != '0 && rx_full) : (wr_left != '0 && tx_empty);
  wire ack_done  = tick && st == S_ACK && q == 2'd3;
  wire ack_fail  = ack_done && write_ph && ack_in;
  wire leave     = (ack_done && !ack_fail) || (tick && st == S_WAIT && !stop_pend);
  wire do_adv    = leave && !need_wait;
  wire adv_pop   = !reading && wr_left != '0;
  wire adv_rs    = !reading && wr_left == '0 && rd_left != '0;
  wire adv_read  = reading && rd_left != '0;
  wire tx_pop_i  = do_adv && adv_pop;
  wire rx_push_i = tick && st == S_XFER && q == 2'd2 && !write_ph && bitn == 3'd7;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (!busy || cnt == '0) cnt <= div;
    else cnt <= cnt - 1'b1;

  always_ff @(posedge clk)
    if (tx_push && tx_level != FULL) tx_mem[tx_wp[AW-1:0]] <= tx_byte;

  always_ff @(posedge clk)
    if (rx_push_i) rx_mem[rx_wp[AW-1:0]] <= {sh[6:0], sda_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push && tx_level != FULL) tx_wp <= tx_wp + 1'b1;
      if (tx_pop_i) tx_rp <= tx_rp + 1'b1;
      if (rx_push_i && !rx_full) rx_wp <= rx_wp + 1'b1;
      if (rx_pop && rx_level != '0) rx_rp <= rx_rp + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stop_pend <= 1'b0;
    else if (!busy) stop_pend <= 1'b0;
    else if (stop_req && st == S_WAIT) stop_pend <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bitn <= '0; sh <= '1; addr <= '0;
      wr_left <= '0; rd_left <= '0; is_addr <= 1'b0; reading <= 1'b0;
      restart <= 1'b0; ack_in <= 1'b1; nack_err <= 1'b0;
    end else if (st == S_IDLE) begin
      q <= '0;
      if (go) begin
        addr     <= dev_addr;
        wr_left  <= wr_len;
        rd_left  <= rd_len;
        reading  <= wr_len == '0 && rd_len != '0;
        restart  <= 1'b0;
        is_addr  <= 1'b0;
        nack_err <= 1'b0;
        st       <= S_START;
      end
    end else if (tick) begin
      if (st != S_WAIT) q <= q + 2'd1;
      case (st)
        S_START: if (q == 2'd3) begin
          st <= S_XFER; bitn <= '0; is_addr <= 1'b1; restart <= 1'b0;
          sh <= {addr, reading};
        end
        S_XFER: begin
          if (q == 2'd2 && !write_ph) begin
            sh <= {sh[6:0], sda_in};
            if (bitn == 3'd7) rd_left <= rd_left - 1'b1;
          end
          if (q == 2'd3) begin
            if (write_ph) sh <= {sh[6:0], 1'b1};
            if (bitn == 3'd7) st <= S_ACK;
            else bitn <= bitn + 3'd1;
          end
        end
        S_ACK: begin
          if (q == 2'd2) ack_in <= sda_in;
          if (ack_fail) begin st <= S_STOP; nack_err <= 1'b1; end
        end
        S_WAIT: if (stop_pend) st <= S_STOP;
        S_STOP: if (q == 2'd3) st <= S_IDLE;
        default: ;
      endcase
      if (do_adv) begin
        is_addr <= 1'b0;
        if (adv_pop) begin
          sh <= tx_mem[tx_rp[AW-1:0]]; wr_left <= wr_left - 1'b1;
          bitn <= '0; st <= S_XFER;
        end else if (adv_rs) begin
          reading <= 1'b1; restart <= 1'b1; st <= S_START;
        end else if (adv_read) begin
          bitn <= '0; st <= S_XFER;
        end else st <= S_STOP;
      end else if (leave) begin
        is_addr <= 1'b0; st <= S_WAIT;
      end
    end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (q == 2'd0 && restart) || q == 2'd3;
        sda_oe = q[1];
      end
      S_XFER: begin
        scl_oe = q == 2'd0 || q == 2'd3;
        sda_oe = write_ph && !sh[7];
      end
      S_ACK: begin
        scl_oe = q == 2'd0 || q == 2'd3;
        sda_oe = !write_ph && rd_left != '0;
      end
      S_WAIT: scl_oe = 1'b1;
      S_STOP: begin
        scl_oe = q == 2'd0;
        sda_oe = !q[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_fifo_master_chk.sv
module i2c_fifo_master_chk #(
  parameter int DEPTH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic [2:0] st,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic waiting,
  input logic nack_err,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic [$clog2(DEPTH):0] rx_level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  // R10
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (st == 3'd2 || st == 3'd3)) |-> $stable(sda_oe));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> scl_oe);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R11
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= FULL);

  // R11
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= FULL);

  // R8
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> st == 3'd5);
endmodule

bind i2c_fifo_master i2c_fifo_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .waiting(waiting), .nack_err(nack_err),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/tb_i2c_fifo_master.sv
`timescale 1ns/1ps
module tb_i2c_fifo_master;
  localparam int DEPTH = 4;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 0, rst_n = 0;
  logic [7:0] div = 0;
  logic tx_push = 0, rx_pop = 0, go = 0, stop_req = 0;
  logic [7:0] tx_byte = 0;
  logic [6:0] dev_addr = 0;
  logic [7:0] wr_len = 0, rd_len = 0;
  logic [2:0] tx_level, rx_level;
  logic [7:0] rx_byte;
  logic busy, waiting, nack_err, scl_oe, sda_oe;
  logic sdrv = 0;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | sdrv);

  i2c_fifo_master #(.DEPTH(DEPTH), .DIV_W(8), .LEN_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .div(div), .tx_push(tx_push), .tx_byte(tx_byte),
    .tx_level(tx_level), .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_level(rx_level),
    .go(go), .dev_addr(dev_addr), .wr_len(wr_len), .rd_len(rd_len),
    .stop_req(stop_req), .busy(busy), .waiting(waiting), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_l));

  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus-level target model
  logic [7:0] wr_log [16];
  logic [7:0] addr_log [4];
  logic mack_log [16];
  int wr_n, rd_n, start_n, stop_n, addr_n, rise_n, nack_at = -1;
  int rise_t [2];
  int bitn_s = 0, kind = 0;
  logic nack_addr = 0, act_s = 0, rw_s = 0, addr_ph = 0, acking = 0, ack_ok = 0;
  logic [7:0] sh_s = 0, out_s = 8'hFF;

  always @(negedge sda_l) if (scl_l) begin
    start_n++; act_s = 1; bitn_s = 0; addr_ph = 1; acking = 0;
  end
  always @(posedge sda_l) if (scl_l) begin stop_n++; act_s = 0; end
  always @(posedge scl_l) begin
    if (rise_n < 2) begin rise_t[rise_n] = cyc; rise_n++; end
    if (act_s) begin
      if (!acking) begin sh_s = {sh_s[6:0], sda_l}; bitn_s++; end
      else if (kind == 2) begin mack_log[rd_n-1] = sda_l; ack_ok = !sda_l; end
    end
  end
  always @(negedge scl_l) if (act_s) begin
    if (acking) begin
      acking = 0; bitn_s = 0;
      if (kind == 0 && !ack_ok) begin act_s = 0; sdrv = 0; end
      else if (rw_s && ack_ok) begin out_s = 8'hA0 + 8'(rd_n); rd_n++; sdrv = !out_s[7]; end
      else sdrv = 0;
    end else if (bitn_s == 8) begin
      acking = 1;
      if (addr_ph) begin
        addr_ph = 0; rw_s = sh_s[0]; addr_log[addr_n] = sh_s; addr_n++;
        ack_ok = (sh_s[7:1] == SLV) && !nack_addr; sdrv = ack_ok; kind = 0;
      end else if (!rw_s) begin
        wr_log[wr_n] = sh_s; ack_ok = (wr_n != nack_at); wr_n++; sdrv = ack_ok; kind = 1;
      end else begin sdrv = 0; kind = 2; end
    end else if (rw_s && !addr_ph && bitn_s > 0 && bitn_s < 8) sdrv = !out_s[7-bitn_s];
  end

  task automatic slave_clear();
    wr_n = 0; rd_n = 0; start_n = 0; stop_n = 0; addr_n = 0; rise_n = 0;
  endtask
  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_byte = b;
    @(negedge clk); tx_push = 0;
  endtask
  task automatic pop_chk(input string req, input logic [7:0] exp);
    @(negedge clk); check(req, rx_byte, exp); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask
  task automatic start(input logic [6:0] a, input int w, input int r);
    slave_clear();
    @(negedge clk); dev_addr = a; wr_len = 8'(w); rd_len = 8'(r); go = 1;
    @(negedge clk); go = 0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic wait_pause();
    while (!waiting) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 scl", scl_oe, 0); check("R1 sda", sda_oe, 0);
    check("R1 busy", busy, 0); check("R1 wait", waiting, 0);
    check("R1 err", nack_err, 0); check("R1 txl", tx_level, 0); check("R1 rxl", rx_level, 0);

    for (int d = 0; d < 3; d++)
      for (int n = 1; n <= 4; n++) begin
        div = 8'(d);
        for (int i = 0; i < n; i++) push(8'((n*16 + i*37 + d*5) & 255));
        start(SLV, n, 0);
        wait_idle();
        check("R2 addr", addr_log[0], {SLV, 1'b0});
        check("R2 count", wr_n, n);
        for (int i = 0; i < n; i++) check("R2 data", wr_log[i], (n*16 + i*37 + d*5) & 255);
        check("R10 starts", start_n, 1); check("R10 stops", stop_n, 1);
        check("R9 period", rise_t[1] - rise_t[0], 4*(d+1));
        check("R2 err", nack_err, 0);
      end

    for (int d = 0; d < 2; d++)
      for (int n = 1; n <= 4; n++) begin
        div = 8'(d);
        start(SLV, 0, n);
        wait_idle();
        check("R3 addr", addr_log[0], {SLV, 1'b1});
        check("R3 level", rx_level, n);
        for (int i = 0; i < n; i++) check("R3 ack", mack_log[i], (i == n-1) ? 1 : 0);
        for (int i = 0; i < n; i++) pop_chk("R3 data", 8'(8'hA0 + i));
        check("R3 stops", stop_n, 1);
      end

    div = 1;
    push(8'h3C); push(8'hC3);
    start(SLV, 2, 3);
    wait_idle();
    check("R4 starts", start_n, 2); check("R4 stops", stop_n, 1);
    check("R4 waddr", addr_log[0], {SLV, 1'b0}); check("R4 raddr", addr_log[1], {SLV, 1'b1});
    check("R4 w0", wr_log[0], 8'h3C); check("R4 w1", wr_log[1], 8'hC3);
    for (int i = 0; i < 3; i++) pop_chk("R4 rdata", 8'(8'hA0 + i));

    for (int i = 0; i < 4; i++) push(8'(8'h10 + i));
    start(SLV, 6, 0);
    wait_pause();
    check("R5 sent", wr_n, 4); check("R5 nostop", stop_n, 0); check("R5 scl", scl_oe, 1);
    repeat (20) @(negedge clk);
    check("R5 still", waiting, 1); check("R5 nostop2", stop_n, 0);
    push(8'h14); push(8'h15);
    wait_idle();
    check("R5 total", wr_n, 6);
    for (int i = 0; i < 6; i++) check("R5 data", wr_log[i], 8'h10 + i);
    check("R5 starts", start_n, 1); check("R5 stops", stop_n, 1);

    start(SLV, 0, 7);
    wait_pause();
    check("R6 full", rx_level, 4); check("R6 nostop", stop_n, 0); check("R6 scl", scl_oe, 1);
    for (int i = 0; i < 4; i++) pop_chk("R6 data", 8'(8'hA0 + i));
    wait_idle();
    check("R6 rest", rx_level, 3);
    for (int i = 4; i < 7; i++) pop_chk("R6 data2", 8'(8'hA0 + i));
    for (int i = 0; i < 7; i++) check("R6 ack", mack_log[i], (i == 6) ? 1 : 0);
    check("R6 stops", stop_n, 1);

    push(8'h77); push(8'h88);
    start(SLV, 5, 0);
    wait_pause();
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
    wait_idle();
    check("R7 sent", wr_n, 2); check("R7 stops", stop_n, 1);
    check("R7 err", nack_err, 0); check("R7 wait", waiting, 0); check("R7 busy", busy, 0);

    nack_addr = 1;
    push(8'h01); push(8'h02);
    start(SLV, 2, 0);
    wait_idle();
    check("R8 aerr", nack_err, 1); check("R8 asent", wr_n, 0);
    check("R8 astop", stop_n, 1); check("R8 kept", tx_level, 2);
    nack_addr = 0;
    start(SLV, 2, 0);
    wait_idle();
    check("R8 clear", nack_err, 0); check("R8 b0", wr_log[0], 8'h01); check("R8 b1", wr_log[1], 8'h02);

    nack_at = 1;
    push(8'h21); push(8'h22); push(8'h23);
    start(SLV, 3, 0);
    wait_idle();
    check("R8 derr", nack_err, 1); check("R8 dsent", wr_n, 2);
    check("R8 dstop", stop_n, 1); check("R8 dleft", tx_level, 1);
    nack_at = -1;
    start(SLV, 1, 0);
    wait_idle();
    check("R8 flush", wr_log[0], 8'h23);

    for (int i = 0; i < 6; i++) push(8'(8'h50 + i));
    check("R11 cap", tx_level, 4);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    check("R11 rxempty", rx_level, 0);
    start(SLV, 4, 0);
    wait_idle();
    for (int i = 0; i < 4; i++) check("R11 order", wr_log[i], 8'h50 + i);
    check("R11 drained", tx_level, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule